// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block is the stall and bubble controller for a five-stage in-order pipeline whose stages run in the order fetch (IF), decode (ID), operand fetch (OF), execute (EX) and writeback (WB). It keeps a control shadow of every in-flight instruction: a valid bit and the decoded fields that matter for hazards, namely the destination register, the register-write and memory-write flags, the memory-read flag, and the two source indexes with their register-operand flags. The decoder presents the fields of the instruction sitting in ID, and the block moves them down the shadow pipeline in step with the datapath. It also owns the program counter, which steps by one instruction width whenever fetch moves.

In every cycle the block picks one stall cause by fixed priority. CAUSE_MULTI (the execute unit reports busy) beats CAUSE_RAW (a register operand in OF is still being produced in EX), which beats CAUSE_PORT (OF wants to read the single data-memory port in the same cycle that WB stores through it). CAUSE_NONE applies when none of these holds. Any cause other than CAUSE_NONE is held only for as long as its condition lasts, and the controller goes back to CAUSE_NONE by itself once the condition clears. The cause is turned into a per-stage hold mask and a per-stage bubble mask. It also decides which request gets the memory port and drives the register-file write strobe from the instruction in WB. The execute datapath, the register file and the memories live outside the block.

Top module: `pipe_interlock_ctrl`

## Requirements
- R1: A synchronous reset clears `pc` to zero and all five `stage_valid` bits, and drives `hold_en`, `bubble_ins`, `rf_we` and both grants low.
- R2: Bit k of `stage_valid`, `hold_en` and `bubble_ins` refers to stage k, where IF=0, ID=1, OF=2, EX=3 and WB=4. `pc` rises by 4 after each clock edge at which `hold_en[0]` is low and is unchanged otherwise. After reset the valid bits fill from IF upward by one stage per cycle.
- R3: Suppose OF holds a valid instruction with a register operand whose index equals the destination of a valid instruction in EX that writes a register and does not store. Then, with the execute unit not busy, `hold_en` is 5'b00111 and `bubble_ins` is 5'b01000 (CAUSE_RAW).
- R4: No register stall is raised when the producer is already in WB, because the register file writes before it reads. None is raised when the matching operand is not a register operand, or when the matching instruction only stores to memory.
- R5: If OF holds a valid memory reader while WB holds a valid store, the block stalls with the same masks as R3 (CAUSE_PORT) and grants the port to the store. The reader proceeds in the next cycle in which no store is in WB.
- R6: `dmem_rd_grant` is high exactly when OF holds a valid memory reader that is not held. `dmem_wr_grant` is high when WB holds a valid store and no read is granted. The two grants are never high together.
- R7: While `ex_busy` is high, `hold_en` is 5'b01111 and `bubble_ins` is 5'b10000 (CAUSE_MULTI), so `pc` freezes and WB holds a bubble in every following cycle.
- R8: `ex_busy` takes priority over a register or port hazard that is present in the same cycle. When busy drops and the hazard remains, the masks of R3 apply again.
- R9: A bubble in WB (`stage_valid[4]` low) produces neither `rf_we` nor `dmem_wr_grant`.
- R10: `rf_we` is high when WB holds a valid instruction that writes a register and does not store, and `rf_waddr` then carries that instruction's destination index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ex_busy | input | 1 | Execute unit needs another cycle for the current operation |
| dec_dest | input | RIDX_W | Destination register of the instruction in ID |
| dec_wr_reg | input | 1 | Instruction in ID writes a register |
| dec_mem_rd | input | 1 | Instruction in ID reads data memory in OF |
| dec_mem_wr | input | 1 | Instruction in ID stores its result to data memory in WB |
| dec_src1 | input | RIDX_W | First source register index |
| dec_src1_reg | input | 1 | First operand comes from the register file |
| dec_src2 | input | RIDX_W | Second source register index |
| dec_src2_reg | input | 1 | Second operand comes from the register file |
| pc | output | PC_W | Fetch address |
| stage_valid | output | 5 | Valid (non-bubble) bit per stage, IF in bit 0 |
| hold_en | output | 5 | Stage keeps its register at the next edge |
| bubble_ins | output | 5 | Stage receives a NOP at the next edge |
| rf_we | output | 1 | Register-file write strobe from WB |
| rf_waddr | output | RIDX_W | Register-file write index from WB |
| dmem_rd_grant | output | 1 | Data-memory port serves the OF read this cycle |
| dmem_wr_grant | output | 1 | Data-memory port serves the WB store this cycle |

## Verification
A multi-cycle execute can start in the same cycle in which a register dependency sits between OF and EX. The bench sets up that dependency with two back-to-back instructions and raises `ex_busy` in the cycle where the dependency is live. It expects the execute-freeze masks in that cycle. One cycle later, with busy released, it expects the register-stall masks while the producer is still in EX, and free flow once the producer reaches WB. A second overlap is a store in WB meeting a reader in OF. For that case the bench checks the stall masks and both grants in the clash cycle and in the cycle after it.

// File: rtl/pil_pkg.sv
package pil_pkg;

    localparam int NUM_STAGES = 5;
    localparam int ST_IF = 0;
    localparam int ST_ID = 1;
    localparam int ST_OF = 2;
    localparam int ST_EX = 3;
    localparam int ST_WB = 4;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_RAW   = 2'd1,
        CAUSE_PORT  = 2'd2,
        CAUSE_MULTI = 2'd3
    } stall_cause_e;

endpackage

// File: rtl/pil_ctrl_pipe.sv
module pil_ctrl_pipe
    import pil_pkg::*;
#(
    parameter int RIDX_W      = 5,
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STAGES-1:0] hold_en,
    input  logic [NUM_STAGES-1:0] bubble_ins,
    input  logic [RIDX_W-1:0]     dec_dest,
    input  logic                  dec_wr_reg,
    input  logic                  dec_mem_rd,
    input  logic                  dec_mem_wr,
    input  logic [RIDX_W-1:0]     dec_src1,
    input  logic                  dec_src1_reg,
    input  logic [RIDX_W-1:0]     dec_src2,
    input  logic                  dec_src2_reg,
    output logic [PC_W-1:0]       pc,
    output logic [NUM_STAGES-1:0] stage_valid,
    output logic [RIDX_W-1:0]     of_src1,
    output logic                  of_src1_reg,
    output logic [RIDX_W-1:0]     of_src2,
    output logic                  of_src2_reg,
    output logic                  of_mem_rd,
    output logic [RIDX_W-1:0]     ex_dest,
    output logic                  ex_wr_reg,
    output logic                  ex_mem_wr,
    output logic [RIDX_W-1:0]     wb_dest,
    output logic                  wb_wr_reg,
    output logic                  wb_mem_wr
);

    typedef struct packed {
        logic              valid;
        logic [RIDX_W-1:0] dest;
        logic              wr_reg;
        logic              mem_rd;
        logic              mem_wr;
        logic [RIDX_W-1:0] src1;
        logic              src1_reg;
        logic [RIDX_W-1:0] src2;
        logic              src2_reg;
    } slot_t;

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_BYTES);

    slot_t slot_q  [NUM_STAGES];
    slot_t slot_in [NUM_STAGES];

    // upstream value offered to each stage
    always_comb begin
        slot_in[ST_IF]          = '0;
        slot_in[ST_IF].valid    = 1'b1;
        slot_in[ST_ID]          = slot_q[ST_IF];
        slot_in[ST_OF].valid    = slot_q[ST_ID].valid;
        slot_in[ST_OF].dest     = dec_dest;
        slot_in[ST_OF].wr_reg   = dec_wr_reg;
        slot_in[ST_OF].mem_rd   = dec_mem_rd;
        slot_in[ST_OF].mem_wr   = dec_mem_wr;
        slot_in[ST_OF].src1     = dec_src1;
        slot_in[ST_OF].src1_reg = dec_src1_reg;
        slot_in[ST_OF].src2     = dec_src2;
        slot_in[ST_OF].src2_reg = dec_src2_reg;
        slot_in[ST_EX]          = slot_q[ST_OF];
        slot_in[ST_WB]          = slot_q[ST_EX];
    end

    // stage registers: hold, bubble or advance
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (rst) begin
                slot_q[s] <= '0;
            end else if (!hold_en[s]) begin
                if (bubble_ins[s]) begin
                    slot_q[s] <= '0;
                end else begin
                    slot_q[s] <= slot_in[s];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (!hold_en[ST_IF]) begin
            pc <= pc + PC_STEP;
        end
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_valid
        assign stage_valid[g] = slot_q[g].valid;
    end

    assign of_src1     = slot_q[ST_OF].src1;
    assign of_src1_reg = slot_q[ST_OF].src1_reg;
    assign of_src2     = slot_q[ST_OF].src2;
    assign of_src2_reg = slot_q[ST_OF].src2_reg;
    assign of_mem_rd   = slot_q[ST_OF].mem_rd;
    assign ex_dest     = slot_q[ST_EX].dest;
    assign ex_wr_reg   = slot_q[ST_EX].wr_reg;
    assign ex_mem_wr   = slot_q[ST_EX].mem_wr;
    assign wb_dest     = slot_q[ST_WB].dest;
    assign wb_wr_reg   = slot_q[ST_WB].wr_reg;
    assign wb_mem_wr   = slot_q[ST_WB].mem_wr;

endmodule

// File: rtl/pil_hazard_detect.sv
module pil_hazard_detect #(
    parameter int RIDX_W         = 5,
    parameter bit WB_WRITE_FIRST = 1'b1
) (
    input  logic              of_valid,
    input  logic [RIDX_W-1:0] of_src1,
    input  logic              of_src1_reg,
    input  logic [RIDX_W-1:0] of_src2,
    input  logic              of_src2_reg,
    input  logic              of_mem_rd,
    input  logic              ex_valid,
    input  logic [RIDX_W-1:0] ex_dest,
    input  logic              ex_wr_reg,
    input  logic              ex_mem_wr,
    input  logic              wb_valid,
    input  logic [RIDX_W-1:0] wb_dest,
    input  logic              wb_wr_reg,
    input  logic              wb_mem_wr,
    output logic              raw_hit,
    output logic              port_hit
);

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0] src_is_reg;
    logic [RIDX_W-1:0]  src_idx [NUM_SRC];
    logic [NUM_SRC-1:0] hit_ex;
    logic [NUM_SRC-1:0] hit_wb;
    logic               ex_produces;
    logic               wb_produces;

    assign src_is_reg  = {of_src2_reg, of_src1_reg};
    assign src_idx[0]  = of_src1;
    assign src_idx[1]  = of_src2;
    assign ex_produces = ex_valid && ex_wr_reg && !ex_mem_wr;
    // with a write-first register file the WB producer needs no wait
    assign wb_produces = !WB_WRITE_FIRST && wb_valid && wb_wr_reg && !wb_mem_wr;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign hit_ex[k] = src_is_reg[k] && ex_produces && (src_idx[k] == ex_dest);
        assign hit_wb[k] = src_is_reg[k] && wb_produces && (src_idx[k] == wb_dest);
    end

    assign raw_hit  = of_valid && ((|hit_ex) || (|hit_wb));
    assign port_hit = of_valid && of_mem_rd && wb_valid && wb_mem_wr;

endmodule

// File: rtl/pil_stall_ctrl.sv
module pil_stall_ctrl
    import pil_pkg::*;
(
    input  logic                  ex_busy,
    input  logic                  raw_hit,
    input  logic                  port_hit,
    output stall_cause_e          cause,
    output logic [NUM_STAGES-1:0] hold_en,
    output logic [NUM_STAGES-1:0] bubble_ins
);

    logic [NUM_STAGES-1:0] front_mask;
    logic [NUM_STAGES-1:0] exec_mask;

    always_comb begin
        for (int s = 0; s < NUM_STAGES; s++) begin
            front_mask[s] = (s <= ST_OF);
            exec_mask[s]  = (s <= ST_EX);
        end
    end

    // cause selection, busy first
    always_comb begin
        if (ex_busy) begin
            cause = CAUSE_MULTI;
        end else if (raw_hit) begin
            cause = CAUSE_RAW;
        end else if (port_hit) begin
            cause = CAUSE_PORT;
        end else begin
            cause = CAUSE_NONE;
        end
    end

    // mask decode per cause
    always_comb begin
        hold_en    = '0;
        bubble_ins = '0;
        unique case (cause)
            CAUSE_NONE: begin
                hold_en = '0;
            end
            CAUSE_RAW, CAUSE_PORT: begin
                hold_en           = front_mask;
                bubble_ins[ST_EX] = 1'b1;
            end
            CAUSE_MULTI: begin
                hold_en           = exec_mask;
                bubble_ins[ST_WB] = 1'b1;
            end
            default: begin
                hold_en = '0;
            end
        endcase
    end

endmodule

// File: rtl/pil_port_arb.sv
module pil_port_arb (
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_grant,
    output logic wr_grant
);

    // the read side always wins the single port
    assign rd_grant = rd_req;
    assign wr_grant = wr_req && !rd_req;

endmodule

// File: rtl/pipe_interlock_ctrl.sv
module pipe_interlock_ctrl
    import pil_pkg::*;
#(
    parameter int RIDX_W         = 5,
    parameter int PC_W           = 32,
    parameter int INSTR_BYTES    = 4,
    parameter bit WB_WRITE_FIRST = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ex_busy,
    input  logic [RIDX_W-1:0]     dec_dest,
    input  logic                  dec_wr_reg,
    input  logic                  dec_mem_rd,
    input  logic                  dec_mem_wr,
    input  logic [RIDX_W-1:0]     dec_src1,
    input  logic                  dec_src1_reg,
    input  logic [RIDX_W-1:0]     dec_src2,
    input  logic                  dec_src2_reg,
    output logic [PC_W-1:0]       pc,
    output logic [NUM_STAGES-1:0] stage_valid,
    output logic [NUM_STAGES-1:0] hold_en,
    output logic [NUM_STAGES-1:0] bubble_ins,
    output logic                  rf_we,
    output logic [RIDX_W-1:0]     rf_waddr,
    output logic                  dmem_rd_grant,
    output logic                  dmem_wr_grant
);

    logic [RIDX_W-1:0] of_src1;
    logic              of_src1_reg;
    logic [RIDX_W-1:0] of_src2;
    logic              of_src2_reg;
    logic              of_mem_rd;
    logic [RIDX_W-1:0] ex_dest;
    logic              ex_wr_reg;
    logic              ex_mem_wr;
    logic [RIDX_W-1:0] wb_dest;
    logic              wb_wr_reg;
    logic              wb_mem_wr;
    logic              raw_hit;
    logic              port_hit;
    logic              rd_req;
    logic              wr_req;
    stall_cause_e      cause;

    pil_ctrl_pipe #(
        .RIDX_W      (RIDX_W),
        .PC_W        (PC_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_pipe (
        .clk          (clk),
        .rst          (rst),
        .hold_en      (hold_en),
        .bubble_ins   (bubble_ins),
        .dec_dest     (dec_dest),
        .dec_wr_reg   (dec_wr_reg),
        .dec_mem_rd   (dec_mem_rd),
        .dec_mem_wr   (dec_mem_wr),
        .dec_src1     (dec_src1),
        .dec_src1_reg (dec_src1_reg),
        .dec_src2     (dec_src2),
        .dec_src2_reg (dec_src2_reg),
        .pc           (pc),
        .stage_valid  (stage_valid),
        .of_src1      (of_src1),
        .of_src1_reg  (of_src1_reg),
        .of_src2      (of_src2),
        .of_src2_reg  (of_src2_reg),
        .of_mem_rd    (of_mem_rd),
        .ex_dest      (ex_dest),
        .ex_wr_reg    (ex_wr_reg),
        .ex_mem_wr    (ex_mem_wr),
        .wb_dest      (wb_dest),
        .wb_wr_reg    (wb_wr_reg),
        .wb_mem_wr    (wb_mem_wr)
    );

    pil_hazard_detect #(
        .RIDX_W         (RIDX_W),
        .WB_WRITE_FIRST (WB_WRITE_FIRST)
    ) u_detect (
        .of_valid    (stage_valid[ST_OF]),
        .of_src1     (of_src1),
        .of_src1_reg (of_src1_reg),
        .of_src2     (of_src2),
        .of_src2_reg (of_src2_reg),
        .of_mem_rd   (of_mem_rd),
        .ex_valid    (stage_valid[ST_EX]),
        .ex_dest     (ex_dest),
        .ex_wr_reg   (ex_wr_reg),
        .ex_mem_wr   (ex_mem_wr),
        .wb_valid    (stage_valid[ST_WB]),
        .wb_dest     (wb_dest),
        .wb_wr_reg   (wb_wr_reg),
        .wb_mem_wr   (wb_mem_wr),
        .raw_hit     (raw_hit),
        .port_hit    (port_hit)
    );

    pil_stall_ctrl u_stall (
        .ex_busy    (ex_busy),
        .raw_hit    (raw_hit),
        .port_hit   (port_hit),
        .cause      (cause),
        .hold_en    (hold_en),
        .bubble_ins (bubble_ins)
    );

    assign rd_req = stage_valid[ST_OF] && of_mem_rd && !hold_en[ST_OF];
    assign wr_req = stage_valid[ST_WB] && wb_mem_wr;

    pil_port_arb u_arb (
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .rd_grant (dmem_rd_grant),
        .wr_grant (dmem_wr_grant)
    );

    assign rf_we    = stage_valid[ST_WB] && wb_wr_reg && !wb_mem_wr;
    assign rf_waddr = wb_dest;

endmodule

// File: rtl/pil_interlock_chk.sv
module pil_interlock_chk #(
    parameter int RIDX_W      = 5,
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ex_busy,
    input logic [PC_W-1:0]   pc,
    input logic [4:0]        stage_valid,
    input logic [4:0]        hold_en,
    input logic [4:0]        bubble_ins,
    input logic              rf_we,
    input logic              dmem_rd_grant,
    input logic              dmem_wr_grant,
    input logic [RIDX_W-1:0] of_src1,
    input logic              of_src1_reg,
    input logic              of_mem_rd,
    input logic [RIDX_W-1:0] ex_dest,
    input logic              ex_wr_reg,
    input logic              ex_mem_wr,
    input logic              wb_mem_wr
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pc == '0 && stage_valid == 5'b00000));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        !hold_en[0] |=> pc == $past(pc) + STEP);

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        hold_en[0] |=> pc == $past(pc));

    p_raw_ex_r3: assert property (@(posedge clk) disable iff (rst)
        (!ex_busy && stage_valid[2] && of_src1_reg && stage_valid[3]
         && ex_wr_reg && !ex_mem_wr && of_src1 == ex_dest)
        |-> (hold_en == 5'b00111 && bubble_ins == 5'b01000));

    p_port_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (!ex_busy && stage_valid[2] && of_mem_rd && stage_valid[4] && wb_mem_wr)
        |-> (hold_en == 5'b00111 && dmem_wr_grant && !dmem_rd_grant));

    p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd_grant && dmem_wr_grant));

    // busy masks hold whatever hazard is present too (R8)
    p_busy_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        ex_busy |-> (hold_en == 5'b01111 && bubble_ins == 5'b10000));

    p_busy_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        ex_busy |=> !stage_valid[4]);

    p_bubble_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !stage_valid[4] |-> (!rf_we && !dmem_wr_grant));

endmodule

bind pipe_interlock_ctrl pil_interlock_chk #(
    .RIDX_W      (RIDX_W),
    .PC_W        (PC_W),
    .INSTR_BYTES (INSTR_BYTES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ex_busy       (ex_busy),
    .pc            (pc),
    .stage_valid   (stage_valid),
    .hold_en       (hold_en),
    .bubble_ins    (bubble_ins),
    .rf_we         (rf_we),
    .dmem_rd_grant (dmem_rd_grant),
    .dmem_wr_grant (dmem_wr_grant),
    .of_src1       (of_src1),
    .of_src1_reg   (of_src1_reg),
    .of_mem_rd     (of_mem_rd),
    .ex_dest       (ex_dest),
    .ex_wr_reg     (ex_wr_reg),
    .ex_mem_wr     (ex_mem_wr),
    .wb_mem_wr     (wb_mem_wr)
);

// File: tb/pipe_interlock_ctrl_bench.sv
module pipe_interlock_ctrl_bench;

    localparam int RIDX_W = 5;
    localparam int PC_W   = 32;

    logic              clk;
    logic              rst;
    logic              ex_busy;
    logic [RIDX_W-1:0] dec_dest;
    logic              dec_wr_reg;
    logic              dec_mem_rd;
    logic              dec_mem_wr;
    logic [RIDX_W-1:0] dec_src1;
    logic              dec_src1_reg;
    logic [RIDX_W-1:0] dec_src2;
    logic              dec_src2_reg;
    logic [PC_W-1:0]   pc;
    logic [4:0]        stage_valid;
    logic [4:0]        hold_en;
    logic [4:0]        bubble_ins;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic              dmem_rd_grant;
    logic              dmem_wr_grant;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    pipe_interlock_ctrl u_pipe_interlock_ctrl (
        .clk           (clk),
        .rst           (rst),
        .ex_busy       (ex_busy),
        .dec_dest      (dec_dest),
        .dec_wr_reg    (dec_wr_reg),
        .dec_mem_rd    (dec_mem_rd),
        .dec_mem_wr    (dec_mem_wr),
        .dec_src1      (dec_src1),
        .dec_src1_reg  (dec_src1_reg),
        .dec_src2      (dec_src2),
        .dec_src2_reg  (dec_src2_reg),
        .pc            (pc),
        .stage_valid   (stage_valid),
        .hold_en       (hold_en),
        .bubble_ins    (bubble_ins),
        .rf_we         (rf_we),
        .rf_waddr      (rf_waddr),
        .dmem_rd_grant (dmem_rd_grant),
        .dmem_wr_grant (dmem_wr_grant)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic set_ins(input logic [4:0] d, input logic w, input logic mr, input logic mw,
                           input logic [4:0] s1, input logic s1r,
                           input logic [4:0] s2, input logic s2r);
        dec_dest = d; dec_wr_reg = w; dec_mem_rd = mr; dec_mem_wr = mw;
        dec_src1 = s1; dec_src1_reg = s1r; dec_src2 = s2; dec_src2_reg = s2r;
    endtask

    task automatic set_nop();
        set_ins(5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
    endtask

    // wait until the instruction in ID has moved into OF
    task automatic push();
        logic held;
        do begin
            held = hold_en[2];
            step();
        end while (held);
    endtask

    task automatic flush();
        set_nop();
        repeat (4) step();
    endtask

    task automatic test_reset();
        rst = 1'b1; ex_busy = 1'b0; set_nop();
        step(); step();
        chk("R1 pc", pc, 32'd0);
        chk("R1 valid", {27'd0, stage_valid}, 32'd0);
        chk("R1 hold", {27'd0, hold_en}, 32'd0);
        chk("R1 bubble", {27'd0, bubble_ins}, 32'd0);
        chk("R1 quiet", {29'd0, rf_we, dmem_rd_grant, dmem_wr_grant}, 32'd0);
        rst = 1'b0;
        step();
        chk("R2 pc first", pc, 32'd4);
        chk("R2 fill1", {27'd0, stage_valid}, 32'h01);
        step();
        chk("R2 pc second", pc, 32'd8);
        chk("R2 fill2", {27'd0, stage_valid}, 32'h03);
        repeat (3) step();
        chk("R2 fill full", {27'd0, stage_valid}, 32'h1f);
        chk("R2 pc fifth", pc, 32'd20);
    endtask

    task automatic test_raw_ex();
        logic [31:0] pc_c1;
        flush();
        set_ins(5'd5, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_ins(5'd0, 1'b0, 1'b0, 1'b0, 5'd5, 1'b1, 5'd0, 1'b0); push();
        set_nop();
        chk("R3 hold", {27'd0, hold_en}, 32'h07);
        chk("R3 bubble", {27'd0, bubble_ins}, 32'h08);
        pc_c1 = pc;
        step();
        chk("R4 wb producer no stall", {27'd0, hold_en}, 32'h00);
        chk("R10 rf_we", {31'd0, rf_we}, 32'd1);
        chk("R10 rf_waddr", {27'd0, rf_waddr}, 32'd5);
        chk("R2 pc held in stall", pc, pc_c1);
        step();
        chk("R9 wb bubble", {31'd0, stage_valid[4]}, 32'd0);
        chk("R9 no rf write", {31'd0, rf_we}, 32'd0);
        chk("R2 pc resumes", pc, pc_c1 + 32'd4);
    endtask

    task automatic test_no_false_stall();
        flush();
        set_ins(5'd6, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_ins(5'd0, 1'b0, 1'b0, 1'b0, 5'd6, 1'b0, 5'd6, 1'b0); push();
        set_nop();
        chk("R4 non-register operand", {27'd0, hold_en}, 32'h00);
        flush();
        set_ins(5'd6, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_ins(5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd6, 1'b1); push();
        set_nop();
        chk("R4 store is not producer", {27'd0, hold_en}, 32'h00);
        flush();
        set_ins(5'd7, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_nop(); push();
        set_ins(5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd7, 1'b1); push();
        set_nop();
        chk("R4 producer two ahead", {27'd0, hold_en}, 32'h00);
        chk("R10 waddr two ahead", {27'd0, rf_waddr}, 32'd7);
    endtask

    task automatic test_port();
        flush();
        set_ins(5'd0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_nop(); push();
        set_ins(5'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_nop();
        chk("R5 clash hold", {27'd0, hold_en}, 32'h07);
        chk("R5 clash bubble", {27'd0, bubble_ins}, 32'h08);
        chk("R5 store granted", {31'd0, dmem_wr_grant}, 32'd1);
        chk("R6 read waits", {31'd0, dmem_rd_grant}, 32'd0);
        step();
        chk("R5 reader proceeds", {27'd0, hold_en}, 32'h00);
        chk("R6 read granted", {31'd0, dmem_rd_grant}, 32'd1);
        chk("R6 no store", {31'd0, dmem_wr_grant}, 32'd0);
        flush();
        set_ins(5'd0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_ins(5'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_nop();
        chk("R5 adjacent no clash", {27'd0, hold_en}, 32'h00);
        chk("R6 adjacent read", {31'd0, dmem_rd_grant}, 32'd1);
        step();
        chk("R6 adjacent store", {31'd0, dmem_wr_grant}, 32'd1);
    endtask

    task automatic test_multi();
        logic [31:0] pc_c1;
        flush();
        set_ins(5'd8, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_nop(); push();
        ex_busy = 1'b1; #1;
        chk("R7 hold", {27'd0, hold_en}, 32'h0f);
        chk("R7 bubble", {27'd0, bubble_ins}, 32'h10);
        pc_c1 = pc;
        step();
        chk("R7 pc frozen", pc, pc_c1);
        chk("R7 wb bubble", {31'd0, stage_valid[4]}, 32'd0);
        chk("R9 no write on bubble", {30'd0, rf_we, dmem_wr_grant}, 32'd0);
        step();
        ex_busy = 1'b0; #1;
        chk("R7 release", {27'd0, hold_en}, 32'h00);
        chk("R7 pc still frozen", pc, pc_c1);
        step();
        chk("R10 slow op writes", {31'd0, rf_we}, 32'd1);
        chk("R10 slow op dest", {27'd0, rf_waddr}, 32'd8);
    endtask

    task automatic test_priority();
        flush();
        set_ins(5'd9, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0); push();
        set_ins(5'd0, 1'b0, 1'b0, 1'b0, 5'd9, 1'b1, 5'd0, 1'b0); push();
        set_nop();
        ex_busy = 1'b1; #1;
        chk("R8 busy wins hold", {27'd0, hold_en}, 32'h0f);
        chk("R8 busy wins bubble", {27'd0, bubble_ins}, 32'h10);
        step();
        ex_busy = 1'b0; #1;
        chk("R8 raw resumes hold", {27'd0, hold_en}, 32'h07);
        chk("R8 raw resumes bubble", {27'd0, bubble_ins}, 32'h08);
        step();
        chk("R8 flow after", {27'd0, hold_en}, 32'h00);
    endtask

    task automatic test_mid_reset();
        flush();
        rst = 1'b1;
        step();
        chk("R1 mid pc", pc, 32'd0);
        chk("R1 mid valid", {27'd0, stage_valid}, 32'd0);
        chk("R1 mid rf_we", {31'd0, rf_we}, 32'd0);
        rst = 1'b0;
        step();
    endtask

    initial begin
        rst = 1'b1; ex_busy = 1'b0; set_nop();
        test_reset();
        test_raw_ex();
        test_no_false_stall();
        test_port();
        test_multi();
        test_priority();
        test_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule